// File: doc/BRIEF.md
# Eight-Bit Arithmetic Logic Unit with Condition Flags

This unit is the arithmetic core of a small microcontroller datapath. Each clock it takes an opcode, a first operand, and a second operand. The second operand is either a register value or an immediate constant, picked by a select input. It also takes the current carry. At the rising edge it registers an 8-bit result, a six-bit condition-flag vector and a six-bit write mask.

The write mask tells the status register which flags this operation defines. The operations form three groups:
- arithmetic: add and subtract, each with and without carry;
- logical: AND, OR, exclusive OR and one's complement;
- bit functions: shifts and rotates by one position.

The sign flag is always the exclusive OR of the negative and overflow flags. A half-carry out of the low nibble is produced for decimal-adjust software.

Instruction decode, the register file, the multiplier and the status register itself lie outside this block. The status register feeds its stored carry back on `cin_i` and writes only the masked flags.

Top module: `alu8_core`

## Requirements
- R1: Outputs are registered. The result, flags and mask seen after a rising edge are computed from the inputs sampled at that edge. A low `rst_n` at a rising edge clears result, flags and mask to zero.
- R2: When `imm_sel_i` is 1 the second operand is `imm_i`; when 0 it is `b_reg_i`. The unselected input has no effect on any output.
- R3: Opcodes 0 (add) and 1 (add with carry) give result = (A + B + k) mod 256. Here k is `cin_i` for opcode 1 and 0 for opcode 0. C is the carry out of bit 7 and H is the carry out of bit 3.
- R4: Opcodes 2 (subtract) and 3 (subtract with borrow) give result = (A − B − k) mod 256. Here k is `cin_i` for opcode 3 and 0 for opcode 2. C is 1 when B + k exceeds A as unsigned numbers. H is 1 when B[3:0] + k exceeds A[3:0].
- R5: For the four arithmetic opcodes, V is 1 exactly when the true signed result of the operands lies outside −128..127.
- R6: The flag vector bit positions are: C bit 0, Z bit 1, N bit 2, V bit 3, S bit 4 and H bit 5. For every flag in the mask, N equals result bit 7 and Z is 1 only for a zero result. S always equals N XOR V.
- R7: Opcodes 4 to 7 give A AND B, A OR B, A XOR B and NOT A. V is 0 and the mask is 6'b011110, so C and H are not written.
- R8: Opcodes 8 to 12 are: shift left (bit 0 gets 0), rotate left through carry, logical shift right, rotate right through carry, and arithmetic shift right (bit 7 kept). C gets the bit shifted out and V = N XOR C. The mask is 6'b011111.
- R9: The arithmetic mask is 6'b111111. Any flag bit outside the mask reads 0. Opcodes 13 to 15 pass A through unchanged with mask and flags all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | First operand |
| b_reg_i | input | 8 | Second operand from register |
| imm_i | input | 8 | Second operand from immediate |
| imm_sel_i | input | 1 | 1 selects the immediate as second operand |
| cin_i | input | 1 | Carry or borrow in from the status register |
| res_o | output | 8 | Registered result |
| flags_o | output | 6 | Registered flags {H,S,V,N,Z,C} |
| fmask_o | output | 6 | Registered flag write mask, same bit order |

## Verification
The hardest cases to reach are the ones where the flags disagree with a plain reading of the result. Examples are a subtract with borrow that wraps to exactly zero, a nibble borrow with no full borrow, and signed overflow that leaves the sign bit clear. These only appear for particular operand pairs combined with a particular carry-in. The stimulus therefore sweeps every first-operand value against a spread of second operands that includes both extremes, 0x7F, 0x80 and values on each side of the nibble boundary. Each pair is run with both carry-in values and through both operand paths, with the unselected path holding the complement so that any leak shows up.

// File: rtl/alu8_pkg.sv
// Shared opcode values and flag bit positions for the 8-bit ALU.
// Assumes a 4-bit opcode field supplied by an external decoder.
package alu8_pkg;
    localparam int FLAG_W = 6;
    localparam int FC = 0;
    localparam int FZ = 1;
    localparam int FN = 2;
    localparam int FV = 3;
    localparam int FS = 4;
    localparam int FH = 5;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_COM = 4'd7,
        OP_LSL = 4'd8,
        OP_ROL = 4'd9,
        OP_LSR = 4'd10,
        OP_ROR = 4'd11,
        OP_ASR = 4'd12
    } alu_op_e;

    localparam logic [FLAG_W-1:0] MASK_ARITH = 6'b111111;
    localparam logic [FLAG_W-1:0] MASK_LOGIC = 6'b011110;
    localparam logic [FLAG_W-1:0] MASK_SHIFT = 6'b011111;
endpackage

// File: rtl/alu8_arith.sv
// Adder/subtractor with carry, half-carry and signed overflow outputs.
// Assumes WIDTH is even; the half-carry is taken at the WIDTH/2 boundary.
module alu8_arith #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    input  logic             use_c,
    input  logic             sub,
    output logic [WIDTH-1:0] r,
    output logic             c,
    output logic             h,
    output logic             v
);
    localparam int HALF = WIDTH / 2;

    logic             k;
    logic [WIDTH:0]   full;
    logic [HALF:0]    low;

    // Carry/borrow extension and the full-width and low-nibble sums.
    always_comb begin
        k = use_c & cin;
        if (sub) begin
            full = {1'b0, a} - {1'b0, b} - {{WIDTH{1'b0}}, k};
            low  = {1'b0, a[HALF-1:0]} - {1'b0, b[HALF-1:0]} - {{HALF{1'b0}}, k};
        end else begin
            full = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, k};
            low  = {1'b0, a[HALF-1:0]} + {1'b0, b[HALF-1:0]} + {{HALF{1'b0}}, k};
        end
    end

    // Result, carry/borrow, half-carry and overflow from the sums.
    always_comb begin
        r = full[WIDTH-1:0];
        c = full[WIDTH];
        h = low[HALF];
        if (sub)
            v = (a[WIDTH-1] & ~b[WIDTH-1] & ~r[WIDTH-1]) |
                (~a[WIDTH-1] & b[WIDTH-1] & r[WIDTH-1]);
        else
            v = (a[WIDTH-1] & b[WIDTH-1] & ~r[WIDTH-1]) |
                (~a[WIDTH-1] & ~b[WIDTH-1] & r[WIDTH-1]);
    end
endmodule

// File: rtl/alu8_logic.sv
// Bitwise unit: AND, OR, XOR and one's complement of the first operand.
// Assumes sel comes from the low two opcode bits of the logical group.
module alu8_logic #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       sel,
    output logic [WIDTH-1:0] r
);
    // Select the bitwise function.
    always_comb begin
        case (sel)
            2'd0:    r = a & b;
            2'd1:    r = a | b;
            2'd2:    r = a ^ b;
            default: r = ~a;
        endcase
    end
endmodule

// File: rtl/alu8_shift.sv
// One-position shifter/rotator; reports the bit moved out as carry.
// Assumes kind 0..4 = shift left, rotate left, shift right, rotate right, arithmetic right.
module alu8_shift #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic             cin,
    input  logic [2:0]       kind,
    output logic [WIDTH-1:0] r,
    output logic             c
);
    // Build the shifted value and the departing bit.
    always_comb begin
        case (kind)
            3'd0: begin r = {a[WIDTH-2:0], 1'b0};        c = a[WIDTH-1]; end
            3'd1: begin r = {a[WIDTH-2:0], cin};         c = a[WIDTH-1]; end
            3'd2: begin r = {1'b0, a[WIDTH-1:1]};        c = a[0];       end
            3'd3: begin r = {cin, a[WIDTH-1:1]};         c = a[0];       end
            default: begin r = {a[WIDTH-1], a[WIDTH-1:1]}; c = a[0];     end
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
// Top of the ALU: picks the second operand, runs the three function units,
// forms the flag vector and write mask, and registers all outputs.
// Assumes the status register feeds back its carry on cin_i and writes only masked flags.
module alu8_core
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [WIDTH-1:0]  a_i,
    input  logic [WIDTH-1:0]  b_reg_i,
    input  logic [WIDTH-1:0]  imm_i,
    input  logic              imm_sel_i,
    input  logic              cin_i,
    output logic [WIDTH-1:0]  res_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic [FLAG_W-1:0] fmask_o
);
    logic [WIDTH-1:0]  opb;
    logic [WIDTH-1:0]  ar_r, lg_r, sh_r;
    logic              ar_c, ar_h, ar_v, sh_c;
    logic              ar_sub, ar_usec;
    logic [2:0]        sh_kind;
    logic [WIDTH-1:0]  nx_res;
    logic [FLAG_W-1:0] nx_flags, nx_mask;
    logic              f_c, f_h, f_v, f_n, f_z;

    // Second-operand source selection.
    always_comb opb = imm_sel_i ? imm_i : b_reg_i;

    // Opcode fields steering the arithmetic and shift units.
    always_comb begin
        ar_sub  = op_i[1];
        ar_usec = op_i[0];
        sh_kind = 3'(op_i - 4'd8);
    end

    alu8_arith #(.WIDTH(WIDTH)) u_arith (
        .a(a_i), .b(opb), .cin(cin_i), .use_c(ar_usec), .sub(ar_sub),
        .r(ar_r), .c(ar_c), .h(ar_h), .v(ar_v)
    );

    alu8_logic #(.WIDTH(WIDTH)) u_logic (
        .a(a_i), .b(opb), .sel(op_i[1:0]), .r(lg_r)
    );

    alu8_shift #(.WIDTH(WIDTH)) u_shift (
        .a(a_i), .cin(cin_i), .kind(sh_kind), .r(sh_r), .c(sh_c)
    );

    // Pick the result and the raw C/H/V/mask by operation group.
    always_comb begin
        if (op_i <= OP_SBC) begin
            nx_res = ar_r; f_c = ar_c; f_h = ar_h; f_v = ar_v; nx_mask = MASK_ARITH;
        end else if (op_i <= OP_COM) begin
            nx_res = lg_r; f_c = 1'b0; f_h = 1'b0; f_v = 1'b0; nx_mask = MASK_LOGIC;
        end else if (op_i <= OP_ASR) begin
            nx_res = sh_r; f_c = sh_c; f_h = 1'b0;
            f_v = sh_r[WIDTH-1] ^ sh_c; nx_mask = MASK_SHIFT;
        end else begin
            nx_res = a_i; f_c = 1'b0; f_h = 1'b0; f_v = 1'b0; nx_mask = '0;
        end
    end

    // Assemble the flag vector; flags outside the mask are forced low.
    always_comb begin
        f_n = nx_res[WIDTH-1];
        f_z = (nx_res == '0);
        nx_flags = '0;
        nx_flags[FC] = f_c;
        nx_flags[FZ] = f_z;
        nx_flags[FN] = f_n;
        nx_flags[FV] = f_v;
        nx_flags[FS] = f_n ^ f_v;
        nx_flags[FH] = f_h;
        nx_flags = nx_flags & nx_mask;
    end

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o   <= '0;
            flags_o <= '0;
            fmask_o <= '0;
        end else begin
            res_o   <= nx_res;
            flags_o <= nx_flags;
            fmask_o <= nx_mask;
        end
    end
endmodule

// File: rtl/alu8_chk.sv
// Property checker for alu8_core, attached by bind.
// Assumes 8-bit operands and the opcode values of alu8_pkg.
module alu8_chk
    import alu8_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  op_i,
    input logic [7:0]  a_i,
    input logic [7:0]  b_reg_i,
    input logic [7:0]  imm_i,
    input logic        imm_sel_i,
    input logic        cin_i,
    input logic [7:0]  res_o,
    input logic [5:0]  flags_o,
    input logic [5:0]  fmask_o
);
    a_r6_sign_rule: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[FS] == (flags_o[FN] ^ flags_o[FV]));

    a_r6_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
        fmask_o[FZ] |-> (flags_o[FZ] == (res_o == 8'd0)) && (flags_o[FN] == res_o[7]));

    a_r9_unmasked_low: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o & ~fmask_o) == 6'd0);

    a_r3_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == OP_ADD && !$past(imm_sel_i)) |->
        ({flags_o[FC], res_o} == ({1'b0, $past(a_i)} + {1'b0, $past(b_reg_i)})));

    a_r4_sub_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == OP_SUB && $past(imm_sel_i)) |->
        (flags_o[FC] == ($past(imm_i) > $past(a_i))));

    a_r7_logic_mask: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) >= OP_AND && $past(op_i) <= OP_COM) |->
        (fmask_o == MASK_LOGIC && !flags_o[FV]));

    a_r8_shift_v: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) >= OP_LSL && $past(op_i) <= OP_ASR) |->
        (flags_o[FV] == (flags_o[FN] ^ flags_o[FC])));

    a_r1_hold_from_inputs: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) > OP_ASR) |->
        (res_o == $past(a_i) && fmask_o == 6'd0));
endmodule

bind alu8_core alu8_chk u_alu8_chk (.*);

// File: tb/tb_alu8_core.sv
// Sweep bench for alu8_core with an arithmetic reference model.
module tb_alu8_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = '0;
    logic [7:0] a_i = '0, b_reg_i = '0, imm_i = '0;
    logic       imm_sel_i = 1'b0, cin_i = 1'b0;
    logic [7:0] res_o;
    logic [5:0] flags_o, fmask_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5ns clk = ~clk;

    alu8_core dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_reg_i(b_reg_i),
        .imm_i(imm_i), .imm_sel_i(imm_sel_i), .cin_i(cin_i),
        .res_o(res_o), .flags_o(flags_o), .fmask_o(fmask_o)
    );

    function automatic string req_of(int op);
        if (op <= 1) return "R3/R5/R6";
        if (op <= 3) return "R4/R5/R6";
        if (op <= 7) return "R7/R6";
        if (op <= 12) return "R8/R6";
        return "R9";
    endfunction

    // Reference: integer arithmetic on the stated requirements.
    task automatic model(input int op, input int a, input int b, input int ci,
                         output logic [7:0] r, output logic [5:0] fl, output logic [5:0] mk);
        int s, sa, sb, sv, k, c, h, v, n, z, rr;
        sa = (a >= 128) ? a - 256 : a;
        sb = (b >= 128) ? b - 256 : b;
        k = (op == 1 || op == 3) ? ci : 0;
        c = 0; h = 0; v = 0; rr = a; mk = 6'b000000;
        if (op <= 1) begin
            s = a + b + k; rr = s % 256; c = (s > 255);
            h = ((a % 16) + (b % 16) + k) > 15;
            sv = sa + sb + k; v = (sv > 127 || sv < -128); mk = 6'b111111;
        end else if (op <= 3) begin
            s = a - b - k; rr = (s + 256) % 256; c = (s < 0);
            h = ((a % 16) - (b % 16) - k) < 0;
            sv = sa - sb - k; v = (sv > 127 || sv < -128); mk = 6'b111111;
        end else if (op <= 7) begin
            case (op)
                4: rr = a & b;
                5: rr = a | b;
                6: rr = a ^ b;
                default: rr = 255 - a;
            endcase
            mk = 6'b011110;
        end else if (op <= 12) begin
            case (op)
                8:  begin rr = (a * 2) % 256;            c = a / 128; end
                9:  begin rr = (a * 2) % 256 + ci;       c = a / 128; end
                10: begin rr = a / 2;                    c = a % 2;   end
                11: begin rr = a / 2 + 128 * ci;         c = a % 2;   end
                default: begin rr = a / 2 + (a / 128) * 128; c = a % 2; end
            endcase
            v = (rr / 128) ^ c; mk = 6'b011111;
        end
        n = rr / 128; z = (rr == 0);
        r = 8'(rr);
        fl = {1'(h), 1'(n ^ v), 1'(v), 1'(n), 1'(z), 1'(c)} & mk;
    endtask

    task automatic run_vec(input int op, input int a, input int b, input int ci, input bit sel);
        logic [7:0] er; logic [5:0] ef, em;
        op_i = 4'(op); a_i = 8'(a); cin_i = ci[0]; imm_sel_i = sel;
        // R2: the unused source carries the complement to expose leaks.
        if (sel) begin imm_i = 8'(b); b_reg_i = ~8'(b); end
        else     begin b_reg_i = 8'(b); imm_i = ~8'(b); end
        model(op, a, b, ci, er, ef, em);
        @(negedge clk);
        checks++;
        if (res_o !== er || flags_o !== ef || fmask_o !== em) begin
            errors++;
            $display("FAIL %s%s op=%0d a=%h b=%h cin=%0d sel=%0d actual res=%h flags=%b mask=%b expected res=%h flags=%b mask=%b",
                     req_of(op), sel ? "/R2" : "", op, a, b, ci, sel,
                     res_o, flags_o, fmask_o, er, ef, em);
        end
    endtask

    task automatic check_reset(input string tag);
        checks++;
        if (res_o !== 8'd0 || flags_o !== 6'd0 || fmask_o !== 6'd0) begin
            errors++;
            $display("FAIL R1 %s actual res=%h flags=%b mask=%b expected all zero",
                     tag, res_o, flags_o, fmask_o);
        end
    endtask

    initial begin
        int bvals[16] = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h7F, 8'h80, 8'hFF, 8'hFE,
                          8'h08, 8'h07, 8'h55, 8'hAA, 8'h3C, 8'h81, 8'h40, 8'hC3};
        repeat (3) @(negedge clk);
        check_reset("initial");
        rst_n = 1'b1;
        // R3 R4 R5: arithmetic, all A, spread of B, both carries, both sources.
        for (int op = 0; op <= 3; op++)
            for (int a = 0; a < 256; a++)
                for (int j = 0; j < 16; j++)
                    for (int ci = 0; ci < 2; ci++)
                        run_vec(op, a, bvals[j], ci, (a + j + ci) % 2 == 1);
        // R7: logical group.
        for (int op = 4; op <= 7; op++)
            for (int a = 0; a < 256; a++)
                for (int j = 0; j < 16; j++)
                    run_vec(op, a, bvals[j], j % 2, (a + j) % 2 == 0);
        // R8: shifts and rotates, exhaustive over A and carry.
        for (int op = 8; op <= 12; op++)
            for (int a = 0; a < 256; a++)
                for (int ci = 0; ci < 2; ci++)
                    run_vec(op, a, 8'h5A, ci, ci == 1);
        // R9: unassigned opcodes.
        for (int op = 13; op <= 15; op++)
            for (int a = 0; a < 256; a++)
                run_vec(op, a, 8'hFF, a % 2, 1'b0);
        // R1: reset mid-run clears registered outputs.
        run_vec(1, 8'hFF, 8'hFF, 1, 1'b0);
        rst_n = 1'b0;
        op_i = 4'd1; a_i = 8'hFF; b_reg_i = 8'hFF; cin_i = 1'b1;
        @(negedge clk);
        check_reset("mid-run");
        rst_n = 1'b1;
        run_vec(2, 8'h00, 8'h01, 0, 1'b0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(150000 * 10ns);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule